// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps four banks of 2-bit saturating counters. A 2-bit register records the outcomes of the last two resolved branches, and its value picks the bank that supplies the prediction. Word-address bits of the fetch PC pick the counter inside that bank. In this way one branch can learn a different direction for each recent outcome pattern of the branches before it.

The fetch stage presents a PC and gets back, in the same cycle, a taken/not-taken prediction and the history value that was used. That history value travels down the pipeline with the branch. When the branch resolves, the resolve port returns the branch PC, the real outcome and that saved history. The block moves the counter in the bank named by the saved history, not the bank named by the current register value. It then shifts the outcome into the history register.

After reset a small state machine has two states. In ST_CLEAR it sweeps one index per cycle and writes every counter to weakly not-taken; resolves are ignored and `ready` is low. When the last index is cleared it takes the transition CLEAR_DONE to ST_RUN. It stays in ST_RUN until the next reset, with `ready` high.

Top module: `bp_corr_predictor`

## Requirements
- R1: After reset `ready` is low and `pred_hist` is 2'b00. `ready` goes high exactly 2^IDX_W cycles after reset is released (1024 by default) and then stays high.
- R2: A resolve presented while `ready` is low has no effect. `pred_hist` stays 2'b00, and the counter it targets still predicts not taken once `ready` is high.
- R3: Every counter starts weakly not-taken (value 1). A never-trained entry predicts not taken, and a single taken update makes it predict taken.
- R4: Counters saturate in the range 0..3, and the prediction is taken for values 2 and 3. After three taken updates, one not-taken update still predicts taken and a second one predicts not taken. After two further not-taken updates, one taken update still predicts not taken.
- R5: Each accepted resolve shifts the history register. Bit 0 of `pred_hist` becomes the newest outcome and bit 1 takes the previous bit 0 (1 = taken).
- R6: Each of the four history values (00, 01, 10, 11) selects its own counter bank. Training one PC under one history value leaves the predictions for that PC under the other three values unchanged.
- R7: An update goes to the bank chosen by `res_hist`, whatever value the history register holds when the resolve arrives.
- R8: The counter index is PC bits [IDX_W+1:2]. PCs that differ only in bits [1:0] or above bit IDX_W+1 share a counter. PCs that differ in the index bits do not.
- R9: A single branch whose outcome alternates taken / not taken, and which is resolved back to back, is predicted correctly on every occurrence once the pattern has been seen a few times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | output | 1 | High once counter initialisation is complete |
| fetch_pc | input | PC_W | PC being looked up |
| pred_taken | output | 1 | Prediction for fetch_pc, 1 = taken |
| pred_hist | output | 2 | Current history register, used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_hist | input | 2 | History value saved at prediction time for this branch |

## Verification
One PC is trained with a fixed history value and then probed under all four history values. This separates a correct bank selection from one that ignores history or decodes its bits wrongly. Updates are also issued with a `res_hist` that differs from the live register, which exposes an update that uses the current history instead of the saved one. Counter runs of taken and not-taken outcomes probe the saturation edges and the reset value. PC aliases in the low and high bits check the index slice. Finally, an alternating taken / not-taken branch shows that the predictor learns a pattern that a table indexed by PC alone cannot learn.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'b01;

    typedef enum logic {
        ST_CLEAR,
        ST_RUN
    } init_st_e;

    // Map history {older, newer} to bank: 00->0, 10->1, 01->2, 11->3
    function automatic logic [1:0] bank_of(input logic [1:0] hist);
        return {hist[0], hist[1]};
    endfunction

    function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == 2'b11) ? cur : cur + 2'b01;
        else
            nxt = (cur == 2'b00) ? cur : cur - 2'b01;
        return nxt;
    endfunction

    function automatic logic ctr_pred(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_init_fsm.sv
module bp_init_fsm
    import bp_corr_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             ready
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    init_st_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR)
                idx_q <= idx_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (idx_q == LAST_IDX) state_d = ST_RUN;   // CLEAR_DONE
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        clr_en  = 1'b0;
        ready   = 1'b0;
        clr_idx = idx_q;
        unique case (state_q)
            ST_CLEAR: clr_en = 1'b1;
            ST_RUN:   ready  = 1'b1;
            default:  clr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       outcome,
    output logic [1:0] hist
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= 2'b00;
        else if (shift_en)
            hist <= {hist[0], outcome};
    end
endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
    import bp_corr_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_en)
            mem[clr_idx] <= CTR_WEAK_NT;
        else if (wr_en)
            mem[wr_idx] <= ctr_next(mem[wr_idx], wr_taken);
    end

    assign rd_ctr = mem[rd_idx];
endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor
    import bp_corr_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            ready,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [1:0]      pred_hist,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [1:0]      res_hist
);
    localparam int NBANK = 4;

    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             upd;
    logic [1:0]       wr_bank, rd_bank;
    ctr_t             bank_ctr [NBANK];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_W+2], fetch_pc[1:0],
                              res_pc[PC_W-1:IDX_W+2], res_pc[1:0]};

    bp_init_fsm #(.IDX_W(IDX_W)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .ready   (ready)
    );

    assign upd = ready & res_valid;

    bp_hist_reg u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd),
        .outcome  (res_taken),
        .hist     (pred_hist)
    );

    assign rd_idx  = fetch_pc[IDX_W+1:2];
    assign wr_idx  = res_pc[IDX_W+1:2];
    assign rd_bank = bank_of(pred_hist);
    assign wr_bank = bank_of(res_hist);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .clr_en   (clr_en),
            .clr_idx  (clr_idx),
            .rd_idx   (rd_idx),
            .rd_ctr   (bank_ctr[b]),
            .wr_en    (upd && (wr_bank == 2'(b))),
            .wr_idx   (wr_idx),
            .wr_taken (res_taken)
        );
    end

    assign pred_taken = ctr_pred(bank_ctr[rd_bank]);
endmodule

// File: rtl/bp_corr_checker.sv
module bp_corr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic [1:0] pred_hist,
    input logic       res_valid,
    input logic       res_taken
);
    // R1: once ready, stays ready
    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1: history is zero until ready
    assert_hist_zero_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> pred_hist == 2'b00);

    // R5: accepted resolve shifts the outcome in
    assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && res_valid) |=> pred_hist == {$past(pred_hist[0]), $past(res_taken)});

    // R2: no accepted resolve, no history change
    assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && res_valid) |=> $stable(pred_hist));
endmodule

bind bp_corr_predictor bp_corr_checker u_bp_corr_checker (.*);

// File: tb/test_bp_corr_predictor.sv
module test_bp_corr_predictor;
    localparam int PC_W  = 32;
    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [PC_W-1:0] SCRATCH = 32'h0000_0FFC;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ready;
    logic [PC_W-1:0] fetch_pc;
    logic            pred_taken;
    logic [1:0]      pred_hist;
    logic            res_valid;
    logic [PC_W-1:0] res_pc;
    logic            res_taken;
    logic [1:0]      res_hist;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bp_corr_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) i_bp_corr_predictor (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic resolve(input logic [PC_W-1:0] pc, input logic tk, input logic [1:0] h);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_hist = h;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic set_hist(input logic [1:0] h);
        resolve(SCRATCH, h[1], 2'b00);
        resolve(SCRATCH, h[0], 2'b00);
    endtask

    task automatic expect_pred(input logic [PC_W-1:0] pc, input logic [1:0] h,
                               input logic exp, input string tag);
        set_hist(h);
        fetch_pc = pc;
        #1;
        check(pred_taken == exp, tag, int'(pred_taken), int'(exp));
    endtask

    task automatic t_reset_init;
        int n = 0;
        rst_n = 1'b0; res_valid = 1'b0; res_pc = '0; res_taken = 1'b0;
        res_hist = 2'b00; fetch_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(ready == 1'b0, "R1 ready low after reset", int'(ready), 0);
        check(pred_hist == 2'b00, "R1 history zero after reset", int'(pred_hist), 0);
        // R2: resolves during init are ignored
        @(negedge clk); n++;
        res_valid = 1'b1; res_pc = 32'h100; res_taken = 1'b1; res_hist = 2'b00;
        @(negedge clk); n++;
        @(negedge clk); n++;
        res_valid = 1'b0;
        check(pred_hist == 2'b00, "R2 history unchanged during init", int'(pred_hist), 0);
        while (!ready && n < 4 * DEPTH) begin
            @(negedge clk); n++;
        end
        check(n == DEPTH, "R1 ready latency", n, DEPTH);
        fetch_pc = 32'h100; #1;
        check(pred_taken == 1'b0, "R2 init-time resolve had no effect", int'(pred_taken), 0);
    endtask

    task automatic t_counter_init;
        expect_pred(32'h200, 2'b00, 1'b0, "R3 fresh entry predicts not taken");
        resolve(32'h200, 1'b1, 2'b00);
        expect_pred(32'h200, 2'b00, 1'b1, "R3 one taken update predicts taken");
    endtask

    task automatic t_saturate;
        repeat (3) resolve(32'h300, 1'b1, 2'b00);
        resolve(32'h300, 1'b0, 2'b00);
        expect_pred(32'h300, 2'b00, 1'b1, "R4 saturated high survives one miss");
        resolve(32'h300, 1'b0, 2'b00);
        expect_pred(32'h300, 2'b00, 1'b0, "R4 two misses flip to not taken");
        repeat (2) resolve(32'h300, 1'b0, 2'b00);
        resolve(32'h300, 1'b1, 2'b00);
        expect_pred(32'h300, 2'b00, 1'b0, "R4 saturated low survives one taken");
    endtask

    task automatic t_hist_shift;
        resolve(SCRATCH, 1'b1, 2'b00);
        resolve(SCRATCH, 1'b0, 2'b00);
        check(pred_hist == 2'b10, "R5 taken then not taken", int'(pred_hist), 2);
        resolve(SCRATCH, 1'b1, 2'b00);
        check(pred_hist == 2'b01, "R5 not taken then taken", int'(pred_hist), 1);
        resolve(SCRATCH, 1'b1, 2'b00);
        check(pred_hist == 2'b11, "R5 taken twice", int'(pred_hist), 3);
    endtask

    task automatic t_bank_select;
        repeat (2) resolve(32'h400, 1'b1, 2'b10);
        expect_pred(32'h400, 2'b00, 1'b0, "R6 history 00 bank untouched");
        expect_pred(32'h400, 2'b01, 1'b0, "R6 history 01 bank untouched");
        expect_pred(32'h400, 2'b11, 1'b0, "R6 history 11 bank untouched");
        expect_pred(32'h400, 2'b10, 1'b1, "R6 history 10 bank trained");
    endtask

    task automatic t_saved_hist;
        set_hist(2'b11);
        repeat (2) resolve(32'h500, 1'b1, 2'b01);
        expect_pred(32'h500, 2'b01, 1'b1, "R7 update went to saved-history bank");
        expect_pred(32'h500, 2'b11, 1'b0, "R7 live-history bank untouched");
    endtask

    task automatic t_index;
        repeat (2) resolve(32'h600, 1'b1, 2'b00);
        expect_pred(32'h601, 2'b00, 1'b1, "R8 low bits ignored");
        expect_pred(32'h1600, 2'b00, 1'b1, "R8 high bits ignored");
        expect_pred(32'h604, 2'b00, 1'b0, "R8 neighbour index separate");
    endtask

    task automatic t_alternate;
        int wrong = 0;
        logic tk = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic [1:0] h;
            logic       p;
            fetch_pc = 32'h700; #1;
            h = pred_hist; p = pred_taken;
            if (i >= 12 && p != tk) wrong++;
            resolve(32'h700, tk, h);
            tk = ~tk;
        end
        check(wrong == 0, "R9 alternating pattern mispredicts after warm-up", wrong, 0);
    endtask

    initial begin
        t_reset_init;
        t_counter_init;
        t_saturate;
        t_hist_shift;
        t_bank_select;
        t_saved_hist;
        t_index;
        t_alternate;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule